// File: doc/BRIEF.md
# Sequential Three-Input Threshold Logic Evaluator

The block computes OR, majority or AND over three single-bit cells that share one memory column. A command gives three row addresses and a two-bit operation code. Once the command is accepted, the block zeroes a small ones counter. It then visits the three rows in turn through a synchronous single-bit memory port. Each visit issues a read and, on the next cycle, adds the returned bit to the counter. In that same cycle it writes the bit back to the same row, so memories whose reads disturb the cell keep their contents. After the third visit the counter is compared against a threshold picked by the operation, and a one-bit result is returned with a one-cycle done pulse.

The block sits next to a column's sense path and is driven by a local sequencer using a start/busy/done handshake. A start that arrives while the block is busy is dropped. Each evaluation performs three restore writes in all, and accepting a command to raising done takes a fixed nine cycles.

FSM states: IDLE (waits for start), CLEAR (zeroes the counter), READ (issues a read of the current row), RESTORE (counts the returned bit and writes it back), DECIDE (registers the result and the done pulse). Transitions: IDLE→CLEAR on an accepted start; CLEAR→READ; READ→RESTORE; RESTORE→READ while operands remain; RESTORE→DECIDE after the third operand; DECIDE→IDLE.

Top module: `col3_thresh_eval`

## Requirements
- R1: After reset, busy, done, result, mem_rd_en and mem_wr_en are all 0.
- R2: A start seen in IDLE latches op and the three rows. busy is 1 on the next cycle and stays 1 until the cycle in which done is 1. While busy is 0, no memory access is made.
- R3: The ones counter is zeroed at the start of every evaluation, so a result never depends on an earlier evaluation.
- R4: The rows are read in the order row_a, row_b, row_c, one at a time. Each read cycle is followed by a write cycle to the same address whose data equal the bit just returned. Read and write are never asserted in the same cycle.
- R5: The counter rises by exactly one for each returned bit equal to 1 and is unchanged for a 0.
- R6: Operation codes are op=00 OR (count ≥ 1), op=01 majority (count ≥ 2) and op=10 AND (count = 3). The reserved code op=11 always gives result 0.
- R7: done is a single-cycle pulse. It appears 9 cycles after the cycle in which start was accepted, with busy already 0. result is valid with done and holds until the next done.
- R8: A start while busy is high has no effect: the running command's result, rows and timing are unchanged.
- R9: With a memory whose read clears the cell, all stored bits are the same after an evaluation as before it, including when one row is named more than once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, honoured only when idle |
| op | input | 2 | Operation code (00 OR, 01 MAJ, 10 AND, 11 reserved) |
| row_a | input | ADDR_W | First operand row |
| row_b | input | ADDR_W | Second operand row |
| row_c | input | ADDR_W | Third operand row |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 1 | Evaluation result, valid with done |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory restore-write request |
| mem_addr | output | ADDR_W | Memory row address |
| mem_wdata | output | 1 | Restore-write data |
| mem_rdata | input | 1 | Read data, valid the cycle after mem_rd_en |

## Verification
The assertions check these rules on every cycle:
- a read and a write never coincide, and every read is followed by a write to the same address carrying the returned bit;
- the counter steps by the returned bit, and it is zero right after busy rises;
- done is a lone pulse with busy low, no memory access happens while idle, and the reserved code never gives a 1.

Only the bench scenarios can show the rest. These are the threshold outcome for every count and operation, the nine-cycle latency, and that a start while busy is dropped. They also show that a destructive-read memory keeps its contents, even when the same row is given three times.

// File: rtl/tlv_pkg.sv
package tlv_pkg;

    localparam int NUM_OPND = 3;
    localparam int CNT_W    = $clog2(NUM_OPND + 1);
    localparam int IDX_W    = $clog2(NUM_OPND);

    typedef enum logic [1:0] {
        OP_OR  = 2'b00,
        OP_MAJ = 2'b01,
        OP_AND = 2'b10,
        OP_RSV = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CLEAR,
        S_READ,
        S_RESTORE,
        S_DECIDE
    } state_e;

endpackage

// File: rtl/tlv_cmd_latch.sv
module tlv_cmd_latch
    import tlv_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [1:0]        op_in,
    input  logic [ADDR_W-1:0] row_a,
    input  logic [ADDR_W-1:0] row_b,
    input  logic [ADDR_W-1:0] row_c,
    input  logic [IDX_W-1:0]  idx,
    output op_e               op_q,
    output logic [ADDR_W-1:0] row_sel
);

    logic [ADDR_W-1:0] rows_in [NUM_OPND];
    logic [ADDR_W-1:0] rows_q  [NUM_OPND];

    assign rows_in[0] = row_a;
    assign rows_in[1] = row_b;
    assign rows_in[2] = row_c;

    // One holding register per operand slot.
    for (genvar g = 0; g < NUM_OPND; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rows_q[g] <= '0;
            end else if (accept) begin
                rows_q[g] <= rows_in[g];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_OR;
        end else if (accept) begin
            op_q <= op_e'(op_in);
        end
    end

    always_comb begin
        row_sel = rows_q[0];
        for (int i = 0; i < NUM_OPND; i++) begin
            if (idx == IDX_W'(i)) begin
                row_sel = rows_q[i];
            end
        end
    end

endmodule

// File: rtl/tlv_ones_acc.sv
module tlv_ones_acc
    import tlv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/tlv_thresh_cmp.sv
module tlv_thresh_cmp
    import tlv_pkg::*;
(
    input  op_e              op,
    input  logic [CNT_W-1:0] cnt,
    output logic             hit
);

    logic [CNT_W-1:0] thr;
    logic             op_ok;

    always_comb begin
        op_ok = 1'b1;
        unique case (op)
            OP_OR:   thr = CNT_W'(1);
            OP_MAJ:  thr = CNT_W'((NUM_OPND + 1) / 2);
            OP_AND:  thr = CNT_W'(NUM_OPND);
            default: begin
                thr   = '0;
                op_ok = 1'b0;
            end
        endcase
        hit = op_ok && (cnt >= thr);
    end

endmodule

// File: rtl/tlv_seq_fsm.sv
module tlv_seq_fsm
    import tlv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rd_bit,
    input  logic             cmp_hit,
    output logic             accept,
    output logic             busy,
    output logic             done,
    output logic             result,
    output logic             clr_acc,
    output logic             inc_acc,
    output logic [IDX_W-1:0] idx,
    output logic             mem_rd_en,
    output logic             mem_wr_en
);

    state_e state_q, state_d;
    logic   last_opnd;

    assign last_opnd = (idx == IDX_W'(NUM_OPND - 1));
    assign accept    = start && (state_q == S_IDLE);

    // State register and operand index.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx     <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_CLEAR) begin
                idx <= '0;
            end else if (state_q == S_RESTORE && !last_opnd) begin
                idx <= idx + IDX_W'(1);
            end
        end
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = S_CLEAR;
            S_CLEAR:   state_d = S_READ;
            S_READ:    state_d = S_RESTORE;
            S_RESTORE: state_d = last_opnd ? S_DECIDE : S_READ;
            S_DECIDE:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Per-state strobes.
    always_comb begin
        busy      = (state_q != S_IDLE);
        clr_acc   = (state_q == S_CLEAR);
        mem_rd_en = (state_q == S_READ);
        mem_wr_en = (state_q == S_RESTORE);
        inc_acc   = (state_q == S_RESTORE) && rd_bit;
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= 1'b0;
        end else begin
            done <= (state_q == S_DECIDE);
            if (state_q == S_DECIDE) begin
                result <= cmp_hit;
            end
        end
    end

endmodule

// File: rtl/col3_thresh_eval.sv
module col3_thresh_eval
    import tlv_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] row_a,
    input  logic [ADDR_W-1:0] row_b,
    input  logic [ADDR_W-1:0] row_c,
    output logic              busy,
    output logic              done,
    output logic              result,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wdata,
    input  logic              mem_rdata
);

    logic             accept;
    logic             clr_acc;
    logic             inc_acc;
    logic             cmp_hit;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] acc_cnt;
    op_e              op_q;

    tlv_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rd_bit    (mem_rdata),
        .cmp_hit   (cmp_hit),
        .accept    (accept),
        .busy      (busy),
        .done      (done),
        .result    (result),
        .clr_acc   (clr_acc),
        .inc_acc   (inc_acc),
        .idx       (idx),
        .mem_rd_en (mem_rd_en),
        .mem_wr_en (mem_wr_en)
    );

    tlv_cmd_latch #(.ADDR_W(ADDR_W)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .op_in   (op),
        .row_a   (row_a),
        .row_b   (row_b),
        .row_c   (row_c),
        .idx     (idx),
        .op_q    (op_q),
        .row_sel (mem_addr)
    );

    tlv_ones_acc u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_acc),
        .inc   (inc_acc),
        .cnt   (acc_cnt)
    );

    tlv_thresh_cmp u_cmp (
        .op  (op_q),
        .cnt (acc_cnt),
        .hit (cmp_hit)
    );

    assign mem_wdata = mem_wr_en & mem_rdata;

endmodule

// File: rtl/tlv_eval_chk.sv
module tlv_eval_chk
    import tlv_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              result,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_wdata,
    input logic              mem_rdata,
    input logic [CNT_W-1:0]  acc,
    input logic [1:0]        op_q
);

    a_r4_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    a_r4_restore_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (mem_wr_en && mem_addr == $past(mem_addr)));

    a_r4_restore_data: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_wdata == mem_rdata));

    a_r5_acc_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> (acc == CNT_W'($past(acc) + CNT_W'($past(mem_rdata)))));

    a_r3_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> (acc == '0));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r2_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !mem_wr_en));

    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == 2'b11) |-> !result);

endmodule

bind col3_thresh_eval tlv_eval_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .acc       (acc_cnt),
    .op_q      (op_q)
);

// File: tb/col3_thresh_eval_tb_top.sv
`timescale 1ns/1ps
module col3_thresh_eval_tb_top;

    localparam int ADDR_W = 6;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LAT    = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        op = 2'b00;
    logic [ADDR_W-1:0] row_a = '0, row_b = '0, row_c = '0;
    logic              busy, done, result;
    logic              mem_rd_en, mem_wr_en, mem_wdata;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rdata;

    logic mem    [DEPTH];
    logic golden [DEPTH];

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    col3_thresh_eval #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .row_a(row_a), .row_b(row_b), .row_c(row_c),
        .busy(busy), .done(done), .result(result),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model: one-cycle read latency, destructive read.
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata     <= mem[mem_addr];
            mem[mem_addr] <= 1'b0;
        end else if (mem_wr_en) begin
            mem[mem_addr] <= mem_wdata;
        end
    end

    function automatic logic exp_result(input logic [1:0] o, input int cnt);
        case (o)
            2'b00:   return cnt >= 1;
            2'b01:   return cnt >= 2;
            2'b10:   return cnt == 3;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_mem(input string req);
        int bad = 0;
        for (int i = 0; i < DEPTH; i++) if (mem[i] !== golden[i]) bad++;
        check(req, "cells differing from stored data", bad, 0);
    endtask

    // Runs one command; when inject is set, a conflicting start is
    // pulsed mid-evaluation (R8).
    task automatic run_cmd(input logic [1:0] o, input logic [ADDR_W-1:0] a,
                           input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] c,
                           input bit inject);
        int cyc;
        int cnt;
        cnt = int'(golden[a]) + int'(golden[b]) + int'(golden[c]);
        @(negedge clk);
        start = 1'b1; op = o; row_a = a; row_b = b; row_c = c;
        @(negedge clk);
        start = 1'b0;
        row_a = ~a; row_b = ~b; row_c = ~c; op = ~o;
        cyc = 1;
        check("R2", "busy after accept", int'(busy), 1);
        while (!done && cyc < 40) begin
            if (inject && cyc == 3) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check("R7", "cycles to done", cyc, LAT);
        check("R7", "busy low with done", int'(busy), 0);
        check(inject ? "R8" : "R6", "result", int'(result), int'(exp_result(o, cnt)));
        @(negedge clk);
        check("R7", "done single pulse", int'(done), 0);
        check("R7", "result held", int'(result), int'(exp_result(o, cnt)));
        check("R2", "idle after done", int'(busy), 0);
        check_mem("R9");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < DEPTH; i++) begin
            golden[i] = 1'($urandom);
            mem[i]    = golden[i];
        end
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", int'(busy), 0);
        check("R1", "done in reset", int'(done), 0);
        check("R1", "result in reset", int'(result), 0);
        check("R1", "memory strobes in reset", int'(mem_rd_en | mem_wr_en), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: every count on rows 0..2, all four codes (R5, R6, R3).
        for (int pat = 0; pat < 8; pat++) begin
            for (int o = 0; o < 4; o++) begin
                golden[0] = pat[0]; golden[1] = pat[1]; golden[2] = pat[2];
                mem[0] = pat[0]; mem[1] = pat[1]; mem[2] = pat[2];
                run_cmd(2'(o), 6'd0, 6'd1, 6'd2, 1'b0);
            end
        end

        // Same row thrice: destructive read must be restored between visits (R9, R5).
        golden[5] = 1'b1; mem[5] = 1'b1;
        run_cmd(2'b10, 6'd5, 6'd5, 6'd5, 1'b0);
        golden[6] = 1'b0; mem[6] = 1'b0;
        run_cmd(2'b00, 6'd6, 6'd6, 6'd6, 1'b0);

        // Start while busy is ignored (R8).
        run_cmd(2'b01, 6'd10, 6'd20, 6'd30, 1'b1);
        run_cmd(2'b10, 6'd7, 6'd8, 6'd9, 1'b1);

        // Random commands (R4 ordering and restore covered by R9 memory check).
        for (int k = 0; k < 60; k++) begin
            run_cmd(2'($urandom), 6'($urandom), 6'($urandom), 6'($urandom),
                    1'($urandom_range(0, 3) == 0));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule